// File: doc/BRIEF.md
# Two-Modulus Prescaler Swallow Divider

This block is the feedback divider of a frequency synthesizer that sits behind an external two-modulus prescaler. Its clock is the prescaler output. Two parallel program words set a 10-bit main count N and a 6-bit swallow count A. From them the block drives the prescaler's modulus select and produces a one-cycle terminal pulse for the phase detector.

Each division period lasts N cycles of the block clock. During the first A of those cycles the modulus select stays low, so the prescaler divides by P+1. For the rest of the period it is high, so the prescaler divides by P. One period therefore takes A(P+1) + (N-A)P = N*P + A cycles at the prescaler input.

Both counters reload in the last cycle of a period, so no input cycles are lost between periods. The program words are sampled only at reload and at reset. Legal programming needs A <= N, and normally A < P. The behaviour for other combinations is defined below. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `swallow_divider`

## Requirements
- R1: A synchronous active-high `rst` loads the main counter from `n_word` and the swallow counter from `a_word`. The first period starts in the first cycle after `rst` falls. In that cycle `mod_ctl` is low if `a_word` was nonzero.
- R2: With N >= 1, `term_pulse` is high for exactly one clock cycle in every N clock cycles. That cycle is the last cycle of each period.
- R3: `mod_ctl` is low (divide by P+1) for the first A cycles of each period and high (divide by P) for the remaining cycles. With A = 0 it is high for the whole period.
- R4: With A <= N, counting P input cycles for each high `mod_ctl` cycle and P+1 for each low one gives N*P + A per period, for any prescaler modulus P.
- R5: Reload costs no cycles. The cycle after `term_pulse` is the first cycle of the next period, with both counters freshly loaded.
- R6: Changes to `n_word` or `a_word` in the middle of a period do not affect that period. They take effect from the next period.
- R7: If A > N, `mod_ctl` stays low for every cycle of the period, and the period still lasts N cycles.
- R8: N = 0 behaves as N = 1: `term_pulse` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output, used as the divider clock |
| rst | input | 1 | Synchronous active-high reset and load |
| n_word | input | 10 | Main count N |
| a_word | input | 6 | Swallow count A |
| mod_ctl | output | 1 | Modulus select: 1 = divide by P, 0 = divide by P+1 |
| term_pulse | output | 1 | One-cycle pulse at the end of each period |

## Verification
A corrupted main count shows up as a terminal pulse that arrives early or late. The error is visible within one period, at most N cycles. A corrupted swallow count moves the rising edge of `mod_ctl` inside the period. It shows up on the first cycle of the period whose modulus is wrong, and it also breaks the N*P+A total for that period. A fault in the reload path appears in the cycle right after the pulse, because that cycle must already carry the new period's values.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  localparam int unsigned MAIN_BITS = 10;
  localparam int unsigned SWAL_BITS = 6;
endpackage

// File: rtl/pdiv_downcnt.sv
module pdiv_downcnt #(
  parameter int unsigned W = 10,
  parameter bit HOLD_AT_ZERO = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reload,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] next_dec;

  generate
    if (HOLD_AT_ZERO) begin : g_hold
      // swallow style: park at zero until the next reload
      assign next_dec = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
    end else begin : g_wrap
      assign next_dec = cnt_q - 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || reload) cnt_q <= load_val;
    else               cnt_q <= next_dec;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pdiv_decode.sv
module pdiv_decode #(
  parameter int unsigned NW = 10,
  parameter int unsigned AW = 6
) (
  input  logic [NW-1:0] main_cnt,
  input  logic [AW-1:0] swal_cnt,
  output logic          last_cyc,
  output logic          swal_done
);
  localparam logic [NW-1:0] ONE_N = NW'(1);

  // a main count of 0 or 1 marks the final cycle of the period
  assign last_cyc  = (main_cnt <= ONE_N);
  assign swal_done = (swal_cnt == '0);
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import pdiv_pkg::*;
#(
  parameter int unsigned NW = MAIN_BITS,
  parameter int unsigned AW = SWAL_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] n_word,
  input  logic [AW-1:0] a_word,
  output logic          mod_ctl,
  output logic          term_pulse
);
  logic [NW-1:0] n_cnt;
  logic [AW-1:0] a_cnt;
  logic          last_cyc;
  logic          swal_done;

  pdiv_downcnt #(.W(NW), .HOLD_AT_ZERO(1'b0)) u_main (
    .clk(clk), .rst(rst), .reload(last_cyc), .load_val(n_word), .cnt(n_cnt)
  );

  pdiv_downcnt #(.W(AW), .HOLD_AT_ZERO(1'b1)) u_swal (
    .clk(clk), .rst(rst), .reload(last_cyc), .load_val(a_word), .cnt(a_cnt)
  );

  pdiv_decode #(.NW(NW), .AW(AW)) u_dec (
    .main_cnt(n_cnt), .swal_cnt(a_cnt), .last_cyc(last_cyc), .swal_done(swal_done)
  );

  assign mod_ctl    = swal_done;
  assign term_pulse = last_cyc;
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
  parameter int unsigned NW = 10,
  parameter int unsigned AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [NW-1:0] n_word,
  input logic [AW-1:0] a_word,
  input logic [NW-1:0] n_cnt,
  input logic          mod_ctl,
  input logic          term_pulse
);
  // R1: leaving reset, the main counter holds the word present at reset
  assert_reset_load_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (n_cnt == $past(n_word)));

  // R2: away from the terminal cycle the main counter steps down by one
  assert_main_step_R2: assert property (@(posedge clk) disable iff (rst)
    !term_pulse |=> (n_cnt == $past(n_cnt) - 1'b1));

  // R5: after the terminal pulse the main counter is freshly loaded
  assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
    term_pulse |=> (n_cnt == $past(n_word)));

  // R3: once divide-by-P is selected it stays selected for the rest of the period
  assert_mod_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mod_ctl && !term_pulse) |=> mod_ctl);

  // R3: a new period opens with divide-by-P only when the swallow word is zero
  assert_mod_open_R3: assert property (@(posedge clk) disable iff (rst)
    term_pulse |=> (mod_ctl == ($past(a_word) == '0)));
endmodule

bind swallow_divider swallow_divider_chk #(.NW(NW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .n_word(n_word), .a_word(a_word),
  .n_cnt(n_cnt), .mod_ctl(mod_ctl), .term_pulse(term_pulse)
);

// File: tb/swallow_divider_tb.sv
module swallow_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] n_word = '0;
  logic [5:0] a_word = '0;
  logic       mod_ctl;
  logic       term_pulse;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  swallow_divider u_dut (
    .clk(clk), .rst(rst), .n_word(n_word), .a_word(a_word),
    .mod_ctl(mod_ctl), .term_pulse(term_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // apply reset with given words; returns at the negedge of the first period cycle
  task automatic do_reset(input int n, input int a);
    @(negedge clk);
    rst = 1'b1; n_word = 10'(n); a_word = 6'(a);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // sample one period at negedges; k counts cycles within it
  task automatic check_period(input int n, input int a, input string tag);
    int ne;
    int inputs;
    ne = (n == 0) ? 1 : n;
    inputs = 0;
    for (int k = 0; k < ne; k++) begin
      chk({tag, " R2 term"}, int'(term_pulse), (k == ne - 1) ? 1 : 0);
      chk({tag, " R3/R7 mod"}, int'(mod_ctl), (k >= a) ? 1 : 0);
      inputs += mod_ctl ? P : P + 1;
      @(negedge clk);
    end
    if (a <= ne && n != 0) chk({tag, " R4 ratio"}, inputs, n * P + a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state with nonzero A
    do_reset(5, 3);
    chk("R1 mod low after reset", int'(mod_ctl), 0);
    chk("R1 no pulse at start", int'(term_pulse), 0);
    // sweep: legal, A=0, A>N (R7) and N=0 (R8); two periods to cover R5
    for (int n = 0; n <= 18; n++) begin
      for (int a = 0; a <= 9; a++) begin
        do_reset(n, a);
        check_period(n, a, "sweep");
        check_period(n, a, "R5 back-to-back");
      end
    end
    // R8: N=0 pulses every cycle
    do_reset(0, 0);
    for (int k = 0; k < 4; k++) begin
      chk("R8 pulse each cycle", int'(term_pulse), 1);
      @(negedge clk);
    end
    // R6: mid-period change applies at next period only
    do_reset(6, 2);
    chk("R6 k0 mod", int'(mod_ctl), 0);
    @(negedge clk);
    n_word = 10'd4; a_word = 6'd3;
    for (int k = 1; k < 6; k++) begin
      chk("R6 old term", int'(term_pulse), (k == 5) ? 1 : 0);
      chk("R6 old mod", int'(mod_ctl), (k >= 2) ? 1 : 0);
      @(negedge clk);
    end
    check_period(4, 3, "R6 new");
    // R1: reset in mid-period restarts the count
    do_reset(9, 4);
    repeat (3) @(negedge clk);
    do_reset(5, 1);
    check_period(5, 1, "R1 mid reset");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule